// File: doc/BRIEF.md
# Bit-Serial Dot-Product Array

This block is a digital compute-in-memory engine. It keeps a grid of stored weights, ROWS rows by COLS columns, and for each row it computes the dot product of that row's weights with one shared input vector. The weights are written once before a computation and stay in place. The inputs are then streamed in, one bit plane per clock: the bench or host drives bit k of every column's input on `xBits` in step k, from least significant to most significant. Each cell multiplies its stored weight by its current input bit. A per-row adder sums the cell outputs, and the row accumulator adds that bit plane with the correct weight for its bit position.

Weight precision and input precision are set separately, each from 1 to 16 bits, through a small configuration register. When both are 1 bit, the block works in binary mode. In that mode each bit stands for +1 or -1 and every cell takes the XNOR of its two bits. At any other setting both operands are two's complement. A longer input precision costs one extra cycle per extra bit. A start pulse clears the accumulators, and a one-cycle done pulse marks valid results. The results then hold until the next start. A weight write that arrives during a computation is dropped and sets an error flag.

Top module: `bitserial_dot_array`

## Requirements
- R1: A `cfgWe` pulse while idle loads the weight precision as `cfgWPrecM1`+1 bits and the input precision as `cfgXPrecM1`+1 bits. The block ignores `cfgWe` while busy. After reset both precisions are 16 bits.
- R2: A `wrEn` pulse while idle stores the 16-bit `wrData` at (`wrRow`, `wrCol`). The computation uses only the low weight-precision bits of a stored word, read as two's complement.
- R3: A `wrEn` pulse while busy leaves the stored weights unchanged and sets `wrErr` on the next edge. `wrErr` stays set until the next accepted start, which clears it.
- R4: A `start` pulse while idle clears every accumulator and raises `busy`. Input bit k of every column is sampled from `xBits` at the (k+1)-th rising edge after the start edge, LSB first.
- R5: When the two precisions are not both 1, row r's result is the sum over columns c of W[r][c]·X[c]. Both operands are two's complement at their own precision, so the top input bit plane carries negative weight.
- R6: When both precisions are 1, a bit value of 1 means +1 and 0 means -1. Each cell contributes +1 when its two bits are equal and -1 otherwise.
- R7: When exactly one operand has 1-bit precision, that operand is 1-bit two's complement: a bit value of 1 means -1 and 0 means 0.
- R8: `done` is high for exactly one cycle. It rises at the edge that is `xPrec` edges after the start edge, and `busy` falls at that same edge.
- R9: The results stay unchanged while idle, even when weights are written or `xBits` changes, until the next accepted start.
- R10: A `start` pulse while busy has no effect on the computation in progress or on when `done` arrives.
- R11: Each row result is 2·16+clog2(COLS)+1 bits wide and signed. Row r sits at `result[r*ACC_W +: ACC_W]`. All-minimum 16-bit operands give the exact result without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Load the precision register |
| cfgWPrecM1 | input | 4 | Weight precision minus one |
| cfgXPrecM1 | input | 4 | Input precision minus one |
| wrEn | input | 1 | Weight write strobe |
| wrRow | input | clog2(ROWS) | Row of the weight to write |
| wrCol | input | clog2(COLS) | Column of the weight to write |
| wrData | input | 16 | Weight word |
| start | input | 1 | Begin a computation |
| xBits | input | COLS | Current input bit plane, one bit per column |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| wrErr | output | 1 | Sticky flag for a weight write made while busy |
| result | output | ROWS·ACC_W | Signed per-row dot products |

## Verification
The bench builds a 3-row by 4-column array. That size keeps full hand-checkable reference sums, and with ROWS not a power of two the row index has a value no row uses. The array is small enough that the bench can sweep the precision pairs that select different arithmetic: 16/16 at the extremes, narrow and mismatched widths, binary mode, and each side alone at 1 bit. The accumulator has 35 bits at this column count, so the all-minimum 16-bit case lands just above the 32-bit range. That exercises the sign headroom for real.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int W_MAX  = 16;
  localparam int PREC_W = 4;

  // Strobes the sequencer hands to the datapath each cycle.
  typedef struct packed {
    logic              clrAcc;
    logic              accEn;
    logic              lastBit;
    logic              binMode;
    logic              wrAccept;
    logic [PREC_W-1:0] bitIdx;
    logic [PREC_W-1:0] wPrecM1;
  } ctrl_strobe_t;

  function automatic int accWidth(input int cols);
    return 2 * W_MAX + ((cols > 1) ? $clog2(cols) : 1) + 1;
  endfunction
endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [PREC_W-1:0] cfgWPrecM1,
  input  logic [PREC_W-1:0] cfgXPrecM1,
  input  logic              wrEn,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              wrErr,
  output ctrl_strobe_t      strobe
);
  logic              busyQ, doneQ, errQ;
  logic [PREC_W-1:0] bitCnt, wPrecQ, xPrecQ;
  logic              startOk, lastBit;

  assign startOk = start && !busyQ;
  assign lastBit = busyQ && (bitCnt == xPrecQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
      bitCnt <= '0;
      wPrecQ <= '1;
      xPrecQ <= '1;
    end else begin
      if (cfgWe && !busyQ) begin
        wPrecQ <= cfgWPrecM1;
        xPrecQ <= cfgXPrecM1;
      end
      if (startOk) begin
        busyQ  <= 1'b1;
        bitCnt <= '0;
        errQ   <= 1'b0;
      end else if (busyQ) begin
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) busyQ <= 1'b0;
      end
      if (wrEn && busyQ) errQ <= 1'b1;
      doneQ <= lastBit;
    end
  end

  assign busy  = busyQ;
  assign done  = doneQ;
  assign wrErr = errQ;

  always_comb begin
    strobe.clrAcc   = startOk;
    strobe.accEn    = busyQ;
    strobe.lastBit  = lastBit;
    strobe.binMode  = (wPrecQ == '0) && (xPrecQ == '0);
    strobe.wrAccept = wrEn && !busyQ;
    strobe.bitIdx   = bitCnt;
    strobe.wPrecM1  = wPrecQ;
  end
endmodule

// File: rtl/bsd_cell.sv
module bsd_cell
  import bsd_pkg::*;
(
  input  logic                    xBit,
  input  logic [W_MAX-1:0]        wVal,
  input  logic [PREC_W-1:0]       wPrecM1,
  output logic signed [W_MAX-1:0] prod,
  output logic                    agree
);
  logic [PREC_W-1:0]       shamt;
  logic signed [W_MAX-1:0] wShl, wExt;

  // Keep the low wPrecM1+1 bits and sign-extend them.
  assign shamt = PREC_W'(W_MAX - 1) - wPrecM1;
  assign wShl  = wVal << shamt;
  assign wExt  = wShl >>> shamt;
  assign prod  = xBit ? wExt : '0;
  assign agree = ~(xBit ^ wVal[0]);
endmodule

// File: rtl/bsd_rowmac.sv
module bsd_rowmac
  import bsd_pkg::*;
#(
  parameter int COLS  = 16,
  parameter int ACC_W = 37
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_strobe_t             strobe,
  input  logic [COLS-1:0]          xBits,
  input  logic [COLS*W_MAX-1:0]    wRow,
  output logic [ACC_W-1:0]         acc
);
  logic signed [W_MAX-1:0] prodArr [COLS];
  logic [COLS-1:0]         agreeVec;

  for (genvar c = 0; c < COLS; c++) begin : g_cell
    bsd_cell u_cell (
      .xBit    (xBits[c]),
      .wVal    (wRow[c*W_MAX +: W_MAX]),
      .wPrecM1 (strobe.wPrecM1),
      .prod    (prodArr[c]),
      .agree   (agreeVec[c])
    );
  end

  logic signed [ACC_W-1:0] ppSum, popCnt, shifted, binTerm, term, delta, accQ;

  always_comb begin
    ppSum  = '0;
    popCnt = '0;
    for (int c = 0; c < COLS; c++) begin
      ppSum  = ppSum + {{(ACC_W-W_MAX){prodArr[c][W_MAX-1]}}, prodArr[c]};
      popCnt = popCnt + ACC_W'(agreeVec[c]);
    end
    shifted = ppSum <<< strobe.bitIdx;
    binTerm = (popCnt <<< 1) - ACC_W'(COLS);
    term    = strobe.binMode ? binTerm : shifted;
    delta   = (strobe.lastBit && !strobe.binMode) ? -term : term;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrAcc) accQ <= '0;
    else if (strobe.accEn)    accQ <= accQ + delta;
  end

  assign acc = accQ;
endmodule

// File: rtl/bsd_datapath.sv
module bsd_datapath
  import bsd_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int ACC_W  = 37,
  parameter int ROW_AW = 4,
  parameter int COL_AW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrl_strobe_t          strobe,
  input  logic [ROW_AW-1:0]     wrRow,
  input  logic [COL_AW-1:0]     wrCol,
  input  logic [W_MAX-1:0]      wrData,
  input  logic [COLS-1:0]       xBits,
  output logic [ROWS*ACC_W-1:0] result
);
  logic [W_MAX-1:0] wMem [ROWS][COLS];
  logic             addrOk;

  assign addrOk = ({1'b0, wrRow} < (ROW_AW+1)'(ROWS)) &&
                  ({1'b0, wrCol} < (COL_AW+1)'(COLS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          wMem[r][c] <= '0;
    end else if (strobe.wrAccept && addrOk) begin
      wMem[wrRow][wrCol] <= wrData;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS*W_MAX-1:0] rowBits;
    for (genvar c = 0; c < COLS; c++) begin : g_pack
      assign rowBits[c*W_MAX +: W_MAX] = wMem[r][c];
    end
    bsd_rowmac #(.COLS(COLS), .ACC_W(ACC_W)) u_mac (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .xBits  (xBits),
      .wRow   (rowBits),
      .acc    (result[r*ACC_W +: ACC_W])
    );
  end
endmodule

// File: rtl/bitserial_dot_array.sv
module bitserial_dot_array
  import bsd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int ACC_W  = accWidth(COLS),
  localparam int ROW_AW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_AW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgWe,
  input  logic [PREC_W-1:0]     cfgWPrecM1,
  input  logic [PREC_W-1:0]     cfgXPrecM1,
  input  logic                  wrEn,
  input  logic [ROW_AW-1:0]     wrRow,
  input  logic [COL_AW-1:0]     wrCol,
  input  logic [W_MAX-1:0]      wrData,
  input  logic                  start,
  input  logic [COLS-1:0]       xBits,
  output logic                  busy,
  output logic                  done,
  output logic                  wrErr,
  output logic [ROWS*ACC_W-1:0] result
);
  ctrl_strobe_t strobe;

  bsd_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgWe      (cfgWe),
    .cfgWPrecM1 (cfgWPrecM1),
    .cfgXPrecM1 (cfgXPrecM1),
    .wrEn       (wrEn),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .wrErr      (wrErr),
    .strobe     (strobe)
  );

  bsd_datapath #(
    .ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W), .ROW_AW(ROW_AW), .COL_AW(COL_AW)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrRow  (wrRow),
    .wrCol  (wrCol),
    .wrData (wrData),
    .xBits  (xBits),
    .result (result)
  );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker
  import bsd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int RES_W = ROWS * accWidth(COLS)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             wrEn,
  input logic             busy,
  input logic             done,
  input logic             wrErr,
  input logic [RES_W-1:0] result
);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_wr_err_r3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && busy) |=> wrErr);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (wrErr && !start) |=> wrErr);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));
endmodule

bind bitserial_dot_array bsd_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .wrEn(wrEn), .busy(busy),
  .done(done), .wrErr(wrErr), .result(result)
);

// File: tb/sim_bitserial_dot_array.sv
module sim_bitserial_dot_array;
  import bsd_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 3;
  localparam int COLS  = 4;
  localparam int ACC_W = accWidth(COLS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 1'b0;
  logic [3:0] cfgWPrecM1 = '0, cfgXPrecM1 = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrRow = '0, wrCol = '0;
  logic [15:0] wrData = '0;
  logic start = 1'b0;
  logic [COLS-1:0] xBits = '0;
  logic busy, done, wrErr;
  logic [ROWS*ACC_W-1:0] result;

  bitserial_dot_array #(.ROWS(ROWS), .COLS(COLS)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  int wP = 16, xP = 16;
  logic [15:0] wMem [ROWS][COLS];
  logic [15:0] xVec [COLS];
  longint expArr [ROWS];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nFail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sx(input logic [15:0] v, input int p);
    longint t = longint'(v) & ((longint'(1) << p) - 1);
    if (((t >> (p - 1)) & 1) != 0) t = t - (longint'(1) << p);
    return t;
  endfunction

  function automatic longint expDot(input int r);
    longint s = 0;
    for (int c = 0; c < COLS; c++) begin
      longint wv, xv;
      if (wP == 1 && xP == 1) begin
        wv = wMem[r][c][0] ? 1 : -1;
        xv = xVec[c][0] ? 1 : -1;
      end else begin
        wv = sx(wMem[r][c], wP);
        xv = sx(xVec[c], xP);
      end
      s += wv * xv;
    end
    return s;
  endfunction

  function automatic longint rowRes(input int r);
    return longint'($signed(result[r*ACC_W +: ACC_W]));
  endfunction

  task automatic setCfg(input int w, input int x);
    @(negedge clk);
    cfgWe = 1'b1; cfgWPrecM1 = 4'(w - 1); cfgXPrecM1 = 4'(x - 1);
    @(negedge clk);
    cfgWe = 1'b0;
    wP = w; xP = x;
  endtask

  task automatic writeW(input int r, input int c, input logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrRow = 2'(r); wrCol = 2'(c); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    wMem[r][c] = v;
  endtask

  task automatic loadAll();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        writeW(r, c, wMem[r][c]);
  endtask

  // Runs one computation; optional injections land at the second bit step.
  task automatic runCheck(input string tag, input bit injW, input bit injS, input bit injC);
    for (int r = 0; r < ROWS; r++) expArr[r] = expDot(r);
    @(negedge clk);
    start = 1'b1; xBits = '0;
    for (int k = 0; k < xP; k++) begin
      @(negedge clk);
      start = 1'b0; wrEn = 1'b0; cfgWe = 1'b0;
      for (int c = 0; c < COLS; c++) xBits[c] = xVec[c][k];
      if (k == 0) chk(busy == 1'b1, {tag, " R4 busy after start"}, longint'(busy), 1);
      chk(done == 1'b0, {tag, " R8 done early"}, longint'(done), 0);
      if (k == 1) begin
        if (injW) begin wrEn = 1'b1; wrRow = 2'd0; wrCol = 2'd0; wrData = 16'h1234; end
        if (injS) start = 1'b1;
        if (injC) begin cfgWe = 1'b1; cfgWPrecM1 = 4'd0; cfgXPrecM1 = 4'd0; end
      end
    end
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0; cfgWe = 1'b0;
    chk(done == 1'b1, {tag, " R8 done at last bit"}, longint'(done), 1);
    chk(busy == 1'b0, {tag, " R8 busy falls"}, longint'(busy), 0);
    for (int r = 0; r < ROWS; r++)
      chk(rowRes(r) == expArr[r], {tag, " R5 row result"}, rowRes(r), expArr[r]);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, longint'(done), 0);
  endtask

  task automatic fillPattern(input int a, input int b);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        wMem[r][c] = 16'((r * 4111 + c * 7919 + a) * 31);
    for (int c = 0; c < COLS; c++) xVec[c] = 16'((c * 40503 + b) * 17);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && done == 1'b0 && wrErr == 1'b0, "R4 reset flags", longint'({busy, done, wrErr}), 0);
    for (int r = 0; r < ROWS; r++) chk(rowRes(r) == 0, "R11 reset result", rowRes(r), 0);
  endtask

  task automatic t_defaultPrec();
    // No cfg write: R1 says both precisions are 16 after reset.
    fillPattern(5, 9);
    loadAll();
    wP = 16; xP = 16;
    runCheck("R1 default 16/16", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_extremes();
    for (int c = 0; c < COLS; c++) begin
      wMem[0][c] = 16'h8000; wMem[1][c] = 16'h7FFF; wMem[2][c] = 16'hFFFF;
      xVec[c] = 16'h8000;
    end
    loadAll();
    setCfg(16, 16);
    runCheck("R11 extremes", 1'b0, 1'b0, 1'b0);
    chk(rowRes(0) == (longint'(1) << 32), "R11 no overflow", rowRes(0), longint'(1) << 32);
  endtask

  task automatic t_mixed(input int w, input int x, input int a, input int b, input string tag);
    fillPattern(a, b);
    loadAll();
    setCfg(w, x);
    runCheck(tag, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busyWrite();
    logic [15:0] old;
    fillPattern(3, 77);
    loadAll();
    setCfg(8, 6);
    old = wMem[0][0];
    runCheck("R3 write during run", 1'b1, 1'b0, 1'b0);
    chk(wrErr == 1'b1, "R3 wrErr set", longint'(wrErr), 1);
    wMem[0][0] = old;
    runCheck("R3 weight unchanged", 1'b0, 1'b0, 1'b0);
    chk(wrErr == 1'b0, "R3 wrErr cleared by start", longint'(wrErr), 0);
  endtask

  task automatic t_busyStartCfg();
    fillPattern(11, 4);
    loadAll();
    setCfg(10, 7);
    runCheck("R10 start during run", 1'b0, 1'b1, 1'b0);
    runCheck("R1 cfg during run", 1'b0, 1'b0, 1'b1);
    runCheck("R1 cfg still 10/7", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    longint keep [ROWS];
    fillPattern(8, 21);
    loadAll();
    setCfg(9, 9);
    runCheck("R9 base", 1'b0, 1'b0, 1'b0);
    for (int r = 0; r < ROWS; r++) keep[r] = rowRes(r);
    writeW(1, 2, 16'h0F0F);
    @(negedge clk); xBits = 4'b1010;
    repeat (3) @(negedge clk);
    for (int r = 0; r < ROWS; r++) chk(rowRes(r) == keep[r], "R9 hold while idle", rowRes(r), keep[r]);
    chk(wrErr == 1'b0, "R3 idle write no error", longint'(wrErr), 0);
    runCheck("R2 idle write takes effect", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_defaultPrec();
    t_extremes();
    t_mixed(8, 8, 1, 2, "R5 8/8");
    t_mixed(3, 11, 7, 13, "R2 narrow weight 3/11");
    t_mixed(16, 2, 19, 5, "R5 16/2");
    t_mixed(12, 16, 23, 29, "R5 12/16");
    t_mixed(1, 1, 2, 3, "R6 binary");
    t_mixed(1, 1, 6, 40, "R6 binary b");
    t_mixed(4, 1, 9, 31, "R7 1-bit input");
    t_mixed(1, 6, 14, 8, "R7 1-bit weight");
    t_busyWrite();
    t_busyStartCfg();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule